// File: doc/BRIEF.md
# Packet Buffer Memory Manager

This block manages a private packet RAM made of 256-byte pages for two clients: a host that builds transmit frames and consumes received ones, and a MAC that sends and receives them. Packets are known only by small packet numbers. A packet's number is the index of its first page. Its pages are contiguous, so a packet can be found without pointers. A bitmap of used pages is searched for the lowest run of free pages that is long enough. A count of pages held back for transmit limits how much memory receive allocations may take.

Three packet-number queues pass packets between the host and the MAC. The transmit queue holds packets that wait to be sent. The completion queue holds packets the MAC has finished. The receive queue holds packets the MAC has filled. A mapping unit turns an 11-bit offset inside a packet into a physical RAM byte address. The packet is either the one named by the host's packet number register or the one at the head of the receive queue.

The host drives one command per cycle. The MAC may request a receive allocation in the same cycle, and that request is served after the host command, on the pages left by it.

Top module: `pb_mmu`

## Requirements
- R1: After a synchronous reset, `free_pages` equals NUM_PAGES, all three queues report empty, and `alloc_res`, `alloc_done`, `rx_ovrn`, `pnr` and `rx_grant` are zero.
- R2: A byte length N needs ceil(N/256) pages, and N = 0 counts as one page. A length that needs more than 8 pages (2 KB) always fails.
- R3: An allocation takes the lowest page index s at which the needed number of consecutive pages are free and fit below NUM_PAGES. The packet number is s.
- R4: Command code 1 (allocate) with length `cmd_len` updates `alloc_res` one cycle later. On success `alloc_res` is {0, packet number}, `free_pages` drops by the page count, and `alloc_done` is set. `alloc_done` stays set until `irq_ack[0]` is pulsed. On failure `alloc_res` is {1, zeros} (bit PKT_W is the fail bit), and `free_pages` and `alloc_done` are unchanged.
- R5: Command code 2 (release) frees every page of the packet whose number is in `pnr` in one cycle. If that number names no allocated packet, nothing changes.
- R6: Command code 3 (enqueue) pushes the current `pnr` value onto the transmit queue. The MAC reads it at `tx_head` and removes it with `tx_pop`. A `pnr` write in the same cycle as a command takes effect only after that command.
- R7: Command code 4 empties the transmit queue and the completion queue, and wins over a push to either queue in the same cycle. The receive queue is not affected.
- R8: `done_push` appends `done_pkt` to the completion queue. Command code 6 removes the head. `done_head` and `done_empty` show the head and the empty flag.
- R9: `rx_alloc_req` with length `rx_len` raises `rx_grant` for exactly one cycle, one cycle later. The request succeeds only if a run of pages is found and the free count before the grant is at least the pages needed plus `tx_reserve`. On success `rx_grant_pkt` names the packet and `rx_grant_fail` is 0.
- R10: A failed receive allocation sets `rx_grant_fail` and `rx_ovrn`. `rx_ovrn` stays set until `irq_ack[1]` is pulsed, and a new failure in the same cycle as the acknowledge wins.
- R11: When a host allocate and a receive request arrive in the same cycle, the host command is served first and the receive request searches the pages left after it.
- R12: `map_addr` = ((pkt + map_off[10:8]) * 256 + map_off[7:0]) modulo 2^ADDR_W. Here pkt is `pnr` when `map_sel` = 0 and the receive queue head when `map_sel` = 1. The output is combinational.
- R13: Every queue is first-in first-out and holds FIFO_DEPTH (18) entries. A push to a full queue is dropped unless the same queue is popped in that cycle. `rx_push` appends `rx_push_pkt` and command code 5 removes the receive head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Host command strobe |
| cmd_op | input | 3 | Command code (1 alloc, 2 release, 3 enqueue, 4 reset transmit queues, 5 pop receive, 6 pop completion) |
| cmd_len | input | LEN_W | Byte length for allocate |
| pnr_wr | input | 1 | Write strobe for packet number register |
| pnr_wdata | input | PKT_W | New packet number register value |
| pnr | output | PKT_W | Packet number register |
| alloc_res | output | PKT_W+1 | Allocation result: fail bit on top, packet number below |
| alloc_done | output | 1 | Latched allocation-done flag |
| rx_ovrn | output | 1 | Latched receive-overrun flag |
| irq_ack | input | 2 | Bit 0 clears alloc_done, bit 1 clears rx_ovrn |
| tx_reserve | input | CNT_W | Pages held back from receive allocations |
| free_pages | output | CNT_W | Number of free pages |
| done_head | output | PKT_W | Completion queue head |
| done_empty | output | 1 | Completion queue empty |
| rx_head | output | PKT_W | Receive queue head |
| rx_empty | output | 1 | Receive queue empty |
| tx_head | output | PKT_W | Transmit queue head |
| tx_empty | output | 1 | Transmit queue empty |
| tx_pop | input | 1 | MAC removes transmit head |
| done_push | input | 1 | MAC appends a completed packet |
| done_pkt | input | PKT_W | Completed packet number |
| rx_alloc_req | input | 1 | MAC receive allocation request |
| rx_len | input | LEN_W | Byte length for receive allocation |
| rx_grant | output | 1 | One-cycle receive allocation response |
| rx_grant_fail | output | 1 | Last receive allocation failed |
| rx_grant_pkt | output | PKT_W | Packet number of last receive grant |
| rx_push | input | 1 | MAC appends a received packet |
| rx_push_pkt | input | PKT_W | Received packet number |
| map_sel | input | 1 | 0 maps through pnr, 1 through receive head |
| map_off | input | 11 | Logical byte offset inside the packet |
| map_addr | output | ADDR_W | Physical RAM byte address |

## Verification
A wrong bit in the used-page bitmap or in the length table shows up within one cycle as a wrong `free_pages` after the next allocate or release. It also shows up as a wrong packet number at the next allocation, when the lowest-first search lands somewhere else. A queue pointer or count error becomes visible at the next pop, as a wrong head or a wrong empty flag. The overflow and flush cases bring out count errors directly. Because the reference model is compared on every clock, any such divergence is reported in the first cycle it reaches a port, not at the end of a sequence.

// File: rtl/pb_mmu_pkg.sv
package pb_mmu_pkg;
    typedef enum logic [2:0] {
        OP_NOP      = 3'd0,
        OP_ALLOC    = 3'd1,
        OP_RELEASE  = 3'd2,
        OP_ENQUEUE  = 3'd3,
        OP_RESET_TX = 3'd4,
        OP_POP_RX   = 3'd5,
        OP_POP_DONE = 3'd6
    } mmu_op_e;

    localparam int PAGE_SHIFT    = 8;
    localparam int LOG_OFF_W     = 11;
    localparam int MAX_PKT_PAGES = (1 << LOG_OFF_W) >> PAGE_SHIFT;
endpackage

// File: rtl/pb_fifo.sv
module pb_fifo #(
    parameter int W     = 5,
    parameter int DEPTH = 18
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    input  logic         flush,
    output logic [W-1:0] head,
    output logic         empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        rd;
        logic [PTR_W-1:0]        wr;
        logic [CNT_W-1:0]        cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     take_d, put_d;

    function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p);
        if (p == PTR_W'(DEPTH - 1)) return '0;
        return p + 1'b1;
    endfunction

    always_comb begin
        st_d   = st_q;
        take_d = pop && (st_q.cnt != '0);
        put_d  = push && ((st_q.cnt != CNT_W'(DEPTH)) || take_d);
        if (flush) begin
            st_d.rd  = '0;
            st_d.wr  = '0;
            st_d.cnt = '0;
        end else begin
            if (take_d) st_d.rd = step_ptr(st_q.rd);
            if (put_d) begin
                st_d.mem[st_q.wr] = push_data;
                st_d.wr           = step_ptr(st_q.wr);
            end
            case ({put_d, take_d})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign head  = st_q.mem[st_q.rd];
    assign empty = (st_q.cnt == '0);
endmodule

// File: rtl/pb_run_finder.sv
module pb_run_finder #(
    parameter int NUM_PAGES = 18,
    parameter int MAXP      = 8,
    parameter int PKT_W     = 5,
    parameter int NEED_W    = 4
) (
    input  logic [NUM_PAGES-1:0] used,
    input  logic [NEED_W-1:0]    need,
    output logic                 found,
    output logic [PKT_W-1:0]     start
);
    logic [NUM_PAGES+MAXP-1:0] ext;
    logic                      fit;

    assign ext = {{MAXP{1'b1}}, used};

    always_comb begin
        found = 1'b0;
        start = '0;
        fit   = 1'b0;
        for (int s = NUM_PAGES - 1; s >= 0; s--) begin
            fit = (need != '0);
            for (int k = 0; k < MAXP; k++) begin
                if ((k < int'(need)) && ext[s+k]) fit = 1'b0;
            end
            if (fit) begin
                found = 1'b1;
                start = PKT_W'(s);
            end
        end
    end
endmodule

// File: rtl/pb_addr_map.sv
module pb_addr_map #(
    parameter int PKT_W  = 5,
    parameter int OFF_W  = 11,
    parameter int SHIFT  = 8,
    parameter int ADDR_W = 13
) (
    input  logic              sel,
    input  logic [PKT_W-1:0]  tx_pkt,
    input  logic [PKT_W-1:0]  rx_pkt,
    input  logic [OFF_W-1:0]  off,
    output logic [ADDR_W-1:0] addr
);
    localparam int PG_W   = PKT_W + 1;
    localparam int FULL_W = PG_W + SHIFT;

    logic [PKT_W-1:0]  pkt;
    logic [PG_W-1:0]   page;
    logic [FULL_W-1:0] full;

    always_comb begin
        pkt  = sel ? rx_pkt : tx_pkt;
        page = {1'b0, pkt} + PG_W'(off[OFF_W-1:SHIFT]);
        full = {page, off[SHIFT-1:0]};
        addr = full[ADDR_W-1:0];
    end
endmodule

// File: rtl/pb_mmu.sv
module pb_mmu
    import pb_mmu_pkg::*;
#(
    parameter int NUM_PAGES  = 18,
    parameter int PKT_W      = 5,
    parameter int FIFO_DEPTH = 18,
    parameter int LEN_W      = 12,
    localparam int CNT_W     = $clog2(NUM_PAGES + 1),
    localparam int ADDR_W    = $clog2(NUM_PAGES << PAGE_SHIFT)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_valid,
    input  logic [2:0]           cmd_op,
    input  logic [LEN_W-1:0]     cmd_len,
    input  logic                 pnr_wr,
    input  logic [PKT_W-1:0]     pnr_wdata,
    output logic [PKT_W-1:0]     pnr,
    output logic [PKT_W:0]       alloc_res,
    output logic                 alloc_done,
    output logic                 rx_ovrn,
    input  logic [1:0]           irq_ack,
    input  logic [CNT_W-1:0]     tx_reserve,
    output logic [CNT_W-1:0]     free_pages,
    output logic [PKT_W-1:0]     done_head,
    output logic                 done_empty,
    output logic [PKT_W-1:0]     rx_head,
    output logic                 rx_empty,
    output logic [PKT_W-1:0]     tx_head,
    output logic                 tx_empty,
    input  logic                 tx_pop,
    input  logic                 done_push,
    input  logic [PKT_W-1:0]     done_pkt,
    input  logic                 rx_alloc_req,
    input  logic [LEN_W-1:0]     rx_len,
    output logic                 rx_grant,
    output logic                 rx_grant_fail,
    output logic [PKT_W-1:0]     rx_grant_pkt,
    input  logic                 rx_push,
    input  logic [PKT_W-1:0]     rx_push_pkt,
    input  logic                 map_sel,
    input  logic [LOG_OFF_W-1:0] map_off,
    output logic [ADDR_W-1:0]    map_addr
);
    localparam int MAXP   = MAX_PKT_PAGES;
    localparam int NEED_W = $clog2(MAXP + 1);

    typedef struct packed {
        logic [NUM_PAGES-1:0]             used;
        logic [NUM_PAGES-1:0][NEED_W-1:0] plen;
        logic [CNT_W-1:0]                 free;
        logic [PKT_W-1:0]                 pnr;
        logic [PKT_W:0]                   res;
        logic                             adone;
        logic                             ovrn;
        logic                             grant;
        logic                             gfail;
        logic [PKT_W-1:0]                 gpkt;
    } mmu_st_t;

    mmu_st_t st_q, st_h, st_d;

    logic [NEED_W-1:0] h_need, r_need;
    logic              h_big, r_big;
    logic              h_found, r_found;
    logic [PKT_W-1:0]  h_start, r_start;
    logic [NEED_W-1:0] rel_len;
    logic              tx_push_c, txq_flush_c, done_pop_c, rx_pop_c;

    function automatic logic [LEN_W:0] pages_of(input logic [LEN_W-1:0] n);
        logic [LEN_W:0] t;
        t = ({1'b0, n} + (LEN_W+1)'((1 << PAGE_SHIFT) - 1)) >> PAGE_SHIFT;
        if (n == '0) t = (LEN_W+1)'(1);
        return t;
    endfunction

    always_comb begin
        logic [LEN_W:0] hp, rp;
        hp     = pages_of(cmd_len);
        rp     = pages_of(rx_len);
        h_big  = (hp > (LEN_W+1)'(MAXP));
        r_big  = (rp > (LEN_W+1)'(MAXP));
        h_need = h_big ? '0 : hp[NEED_W-1:0];
        r_need = r_big ? '0 : rp[NEED_W-1:0];
    end

    pb_run_finder #(
        .NUM_PAGES(NUM_PAGES), .MAXP(MAXP), .PKT_W(PKT_W), .NEED_W(NEED_W)
    ) u_find_host (
        .used(st_q.used), .need(h_need), .found(h_found), .start(h_start)
    );

    always_comb begin
        rel_len = '0;
        for (int p = 0; p < NUM_PAGES; p++) begin
            if (PKT_W'(p) == st_q.pnr) rel_len = st_q.plen[p];
        end
    end

    // Host command stage
    always_comb begin
        st_h       = st_q;
        st_h.grant = 1'b0;
        if (pnr_wr)     st_h.pnr   = pnr_wdata;
        if (irq_ack[0]) st_h.adone = 1'b0;
        if (irq_ack[1]) st_h.ovrn  = 1'b0;
        if (cmd_valid) begin
            case (cmd_op)
                OP_ALLOC: begin
                    if (h_found && !h_big) begin
                        for (int p = 0; p < NUM_PAGES; p++) begin
                            if (p >= int'(h_start) && p < int'(h_start) + int'(h_need))
                                st_h.used[p] = 1'b1;
                            if (p == int'(h_start)) st_h.plen[p] = h_need;
                        end
                        st_h.free  = st_q.free - CNT_W'(h_need);
                        st_h.res   = {1'b0, h_start};
                        st_h.adone = 1'b1;
                    end else begin
                        st_h.res = {1'b1, {PKT_W{1'b0}}};
                    end
                end
                OP_RELEASE: begin
                    if (rel_len != '0) begin
                        for (int p = 0; p < NUM_PAGES; p++) begin
                            if (p >= int'(st_q.pnr) && p < int'(st_q.pnr) + int'(rel_len))
                                st_h.used[p] = 1'b0;
                            if (PKT_W'(p) == st_q.pnr) st_h.plen[p] = '0;
                        end
                        st_h.free = st_q.free + CNT_W'(rel_len);
                    end
                end
                default: ;
            endcase
        end
    end

    pb_run_finder #(
        .NUM_PAGES(NUM_PAGES), .MAXP(MAXP), .PKT_W(PKT_W), .NEED_W(NEED_W)
    ) u_find_rx (
        .used(st_h.used), .need(r_need), .found(r_found), .start(r_start)
    );

    // Receive allocation stage, on the pages left by the host stage
    always_comb begin
        st_d = st_h;
        if (rx_alloc_req) begin
            st_d.grant = 1'b1;
            if (r_found && !r_big &&
                (int'(st_h.free) >= int'(r_need) + int'(tx_reserve))) begin
                for (int p = 0; p < NUM_PAGES; p++) begin
                    if (p >= int'(r_start) && p < int'(r_start) + int'(r_need))
                        st_d.used[p] = 1'b1;
                    if (p == int'(r_start)) st_d.plen[p] = r_need;
                end
                st_d.free  = st_h.free - CNT_W'(r_need);
                st_d.gfail = 1'b0;
                st_d.gpkt  = r_start;
            end else begin
                st_d.gfail = 1'b1;
                st_d.gpkt  = '0;
                st_d.ovrn  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= '0;
            st_q.free <= CNT_W'(NUM_PAGES);
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        tx_push_c   = cmd_valid && (cmd_op == OP_ENQUEUE);
        txq_flush_c = cmd_valid && (cmd_op == OP_RESET_TX);
        rx_pop_c    = cmd_valid && (cmd_op == OP_POP_RX);
        done_pop_c  = cmd_valid && (cmd_op == OP_POP_DONE);
    end

    pb_fifo #(.W(PKT_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst(rst), .push(tx_push_c), .push_data(st_q.pnr),
        .pop(tx_pop), .flush(txq_flush_c), .head(tx_head), .empty(tx_empty)
    );

    pb_fifo #(.W(PKT_W), .DEPTH(FIFO_DEPTH)) u_doneq (
        .clk(clk), .rst(rst), .push(done_push), .push_data(done_pkt),
        .pop(done_pop_c), .flush(txq_flush_c), .head(done_head), .empty(done_empty)
    );

    pb_fifo #(.W(PKT_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .push(rx_push), .push_data(rx_push_pkt),
        .pop(rx_pop_c), .flush(1'b0), .head(rx_head), .empty(rx_empty)
    );

    pb_addr_map #(
        .PKT_W(PKT_W), .OFF_W(LOG_OFF_W), .SHIFT(PAGE_SHIFT), .ADDR_W(ADDR_W)
    ) u_map (
        .sel(map_sel), .tx_pkt(st_q.pnr), .rx_pkt(rx_head), .off(map_off), .addr(map_addr)
    );

    assign pnr           = st_q.pnr;
    assign alloc_res     = st_q.res;
    assign alloc_done    = st_q.adone;
    assign rx_ovrn       = st_q.ovrn;
    assign free_pages    = st_q.free;
    assign rx_grant      = st_q.grant;
    assign rx_grant_fail = st_q.gfail;
    assign rx_grant_pkt  = st_q.gpkt;
endmodule

// File: rtl/pb_mmu_chk.sv
module pb_mmu_chk
    import pb_mmu_pkg::*;
#(
    parameter int NUM_PAGES = 18,
    parameter int PKT_W     = 5,
    localparam int CNT_W    = $clog2(NUM_PAGES + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             cmd_valid,
    input logic [2:0]       cmd_op,
    input logic [1:0]       irq_ack,
    input logic             rx_alloc_req,
    input logic [PKT_W:0]   alloc_res,
    input logic             alloc_done,
    input logic             rx_ovrn,
    input logic [CNT_W-1:0] free_pages,
    input logic             tx_empty,
    input logic             done_empty,
    input logic             rx_grant,
    input logic             rx_grant_fail
);
    assert_free_bound_R1: assert property (@(posedge clk) disable iff (rst)
        free_pages <= CNT_W'(NUM_PAGES));

    assert_fail_keeps_free_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_ALLOC && !rx_alloc_req) |=>
        (!alloc_res[PKT_W] || free_pages == $past(free_pages)));

    assert_success_sets_done_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_ALLOC) |=> (alloc_res[PKT_W] || alloc_done));

    assert_release_no_loss_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_RELEASE && !rx_alloc_req) |=>
        (free_pages >= $past(free_pages)));

    assert_flush_empties_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_RESET_TX) |=> (tx_empty && done_empty));

    assert_grant_next_R9: assert property (@(posedge clk) disable iff (rst)
        rx_alloc_req |=> rx_grant);

    assert_ovrn_latched_R10: assert property (@(posedge clk) disable iff (rst)
        (rx_ovrn && !irq_ack[1]) |=> rx_ovrn);

    assert_fail_raises_ovrn_R10: assert property (@(posedge clk) disable iff (rst)
        (rx_grant && rx_grant_fail) |-> rx_ovrn);
endmodule

bind pb_mmu pb_mmu_chk #(.NUM_PAGES(NUM_PAGES), .PKT_W(PKT_W)) u_chk (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .irq_ack(irq_ack), .rx_alloc_req(rx_alloc_req), .alloc_res(alloc_res),
    .alloc_done(alloc_done), .rx_ovrn(rx_ovrn), .free_pages(free_pages),
    .tx_empty(tx_empty), .done_empty(done_empty), .rx_grant(rx_grant),
    .rx_grant_fail(rx_grant_fail)
);

// File: tb/pb_mmu_tb.sv
module pb_mmu_tb;
    localparam int NP    = 18;
    localparam int PW    = 5;
    localparam int DEP   = 18;
    localparam int LW    = 12;
    localparam int CW    = $clog2(NP + 1);
    localparam int AW    = $clog2(NP * 256);
    localparam int MAXPG = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 0;
    logic [2:0]    cmd_op = 0;
    logic [LW-1:0] cmd_len = 0;
    logic          pnr_wr = 0;
    logic [PW-1:0] pnr_wdata = 0;
    logic [PW-1:0] pnr;
    logic [PW:0]   alloc_res;
    logic          alloc_done, rx_ovrn;
    logic [1:0]    irq_ack = 0;
    logic [CW-1:0] tx_reserve = 0;
    logic [CW-1:0] free_pages;
    logic [PW-1:0] done_head, rx_head, tx_head;
    logic          done_empty, rx_empty, tx_empty;
    logic          tx_pop = 0, done_push = 0;
    logic [PW-1:0] done_pkt = 0;
    logic          rx_alloc_req = 0;
    logic [LW-1:0] rx_len = 0;
    logic          rx_grant, rx_grant_fail;
    logic [PW-1:0] rx_grant_pkt;
    logic          rx_push = 0;
    logic [PW-1:0] rx_push_pkt = 0;
    logic          map_sel = 0;
    logic [10:0]   map_off = 0;
    logic [AW-1:0] map_addr;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    always #10 clk = ~clk;

    pb_mmu u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_len(cmd_len),
        .pnr_wr(pnr_wr), .pnr_wdata(pnr_wdata), .pnr(pnr), .alloc_res(alloc_res),
        .alloc_done(alloc_done), .rx_ovrn(rx_ovrn), .irq_ack(irq_ack),
        .tx_reserve(tx_reserve), .free_pages(free_pages), .done_head(done_head),
        .done_empty(done_empty), .rx_head(rx_head), .rx_empty(rx_empty),
        .tx_head(tx_head), .tx_empty(tx_empty), .tx_pop(tx_pop), .done_push(done_push),
        .done_pkt(done_pkt), .rx_alloc_req(rx_alloc_req), .rx_len(rx_len),
        .rx_grant(rx_grant), .rx_grant_fail(rx_grant_fail), .rx_grant_pkt(rx_grant_pkt),
        .rx_push(rx_push), .rx_push_pkt(rx_push_pkt), .map_sel(map_sel),
        .map_off(map_off), .map_addr(map_addr)
    );

    // ---------------- reference model ----------------
    bit m_used [NP];
    int m_len  [NP];
    int m_pnr, m_res, m_adone, m_ovrn, m_grant, m_gfail, m_gpkt;
    int m_txq[$];
    int m_doneq[$];
    int m_rxq[$];

    function automatic int need_of(int n);
        int p;
        p = (n == 0) ? 1 : (n + 255) / 256;
        return (p > MAXPG) ? 0 : p;
    endfunction

    function automatic int find_run(int need);
        if (need == 0) return -1;
        for (int s = 0; s + need <= NP; s++) begin
            bit ok = 1;
            for (int k = 0; k < need; k++) if (m_used[s+k]) ok = 0;
            if (ok) return s;
        end
        return -1;
    endfunction

    function automatic int m_free();
        int c = 0;
        for (int p = 0; p < NP; p++) if (!m_used[p]) c++;
        return c;
    endfunction

    function automatic void take_pages(int s, int n);
        for (int k = 0; k < n; k++) m_used[s+k] = 1;
        m_len[s] = n;
    endfunction

    function automatic void model_reset();
        for (int p = 0; p < NP; p++) begin m_used[p] = 0; m_len[p] = 0; end
        m_pnr = 0; m_res = 0; m_adone = 0; m_ovrn = 0;
        m_grant = 0; m_gfail = 0; m_gpkt = 0;
        m_txq.delete(); m_doneq.delete(); m_rxq.delete();
    endfunction

    function automatic void model_step();
        int old_pnr, nd, s;
        bit is_cmd;
        old_pnr = m_pnr;
        m_grant = 0;
        if (pnr_wr) m_pnr = int'(pnr_wdata);
        if (irq_ack[0]) m_adone = 0;
        if (irq_ack[1]) m_ovrn = 0;
        is_cmd = cmd_valid;
        if (is_cmd && cmd_op == 3'd1) begin
            nd = need_of(int'(cmd_len));
            s  = find_run(nd);
            if (s >= 0) begin take_pages(s, nd); m_res = s; m_adone = 1; end
            else m_res = 1 << PW;
        end
        if (is_cmd && cmd_op == 3'd2 && old_pnr < NP && m_len[old_pnr] != 0) begin
            for (int k = 0; k < m_len[old_pnr]; k++) m_used[old_pnr+k] = 0;
            m_len[old_pnr] = 0;
        end
        if (rx_alloc_req) begin
            m_grant = 1;
            nd = need_of(int'(rx_len));
            s  = find_run(nd);
            if (s >= 0 && m_free() >= nd + int'(tx_reserve)) begin
                take_pages(s, nd); m_gfail = 0; m_gpkt = s;
            end else begin
                m_gfail = 1; m_gpkt = 0; m_ovrn = 1;
            end
        end
        if (is_cmd && cmd_op == 3'd4) begin
            m_txq.delete(); m_doneq.delete();
        end else begin
            if (tx_pop && m_txq.size() > 0) void'(m_txq.pop_front());
            if (is_cmd && cmd_op == 3'd3 && m_txq.size() < DEP) m_txq.push_back(old_pnr);
            if (is_cmd && cmd_op == 3'd6 && m_doneq.size() > 0) void'(m_doneq.pop_front());
            if (done_push && m_doneq.size() < DEP) m_doneq.push_back(int'(done_pkt));
        end
        if (is_cmd && cmd_op == 3'd5 && m_rxq.size() > 0) void'(m_rxq.pop_front());
        if (rx_push && m_rxq.size() < DEP) m_rxq.push_back(int'(rx_push_pkt));
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        int pk, ex;
        chk("R1", "free_pages", int'(free_pages), m_free());
        chk("R4", "alloc_res", int'(alloc_res), m_res);
        chk("R4", "alloc_done", int'(alloc_done), m_adone);
        chk("R10", "rx_ovrn", int'(rx_ovrn), m_ovrn);
        chk("R6", "pnr", int'(pnr), m_pnr);
        chk("R13", "tx_empty", int'(tx_empty), int'(m_txq.size() == 0));
        if (m_txq.size() > 0) chk("R6", "tx_head", int'(tx_head), m_txq[0]);
        chk("R8", "done_empty", int'(done_empty), int'(m_doneq.size() == 0));
        if (m_doneq.size() > 0) chk("R8", "done_head", int'(done_head), m_doneq[0]);
        chk("R13", "rx_empty", int'(rx_empty), int'(m_rxq.size() == 0));
        if (m_rxq.size() > 0) chk("R13", "rx_head", int'(rx_head), m_rxq[0]);
        chk("R9", "rx_grant", int'(rx_grant), m_grant);
        chk("R9", "rx_grant_fail", int'(rx_grant_fail), m_gfail);
        chk("R9", "rx_grant_pkt", int'(rx_grant_pkt), m_gpkt);
        if (!map_sel || m_rxq.size() > 0) begin
            pk = map_sel ? m_rxq[0] : m_pnr;
            ex = ((pk + (int'(map_off) >> 8)) * 256 + (int'(map_off) & 255)) % (1 << AW);
            chk("R12", "map_addr", int'(map_addr), ex);
        end
    endtask

    initial begin
        model_reset();
        forever begin
            @(posedge clk);
            if (rst) model_reset();
            else     model_step();
            #5;
            if (!done_flag) compare_all();
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic idle();
        cmd_valid = 0; pnr_wr = 0; irq_ack = 0; tx_pop = 0; done_push = 0;
        rx_alloc_req = 0; rx_push = 0;
    endtask

    task automatic host(input logic [2:0] op, input int len);
        @(negedge clk);
        idle();
        cmd_valid = 1; cmd_op = op; cmd_len = LW'(len);
        @(negedge clk);
        idle();
    endtask

    task automatic set_pnr(input int v);
        @(negedge clk);
        idle();
        pnr_wr = 1; pnr_wdata = PW'(v);
        @(negedge clk);
        idle();
    endtask

    task automatic finish_run();
        done_flag = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "free after reset", int'(free_pages), NP);
        chk("R1", "tx empty", int'(tx_empty), 1);
        chk("R1", "done empty", int'(done_empty), 1);
        chk("R1", "rx empty", int'(rx_empty), 1);
        chk("R1", "alloc_done", int'(alloc_done), 0);

        host(3'd1, 600);      // 3 pages
        chk("R3", "first alloc pkt", int'(alloc_res), 0);
        chk("R2", "600 bytes -> 3 pages", int'(free_pages), 15);
        chk("R4", "alloc_done set", int'(alloc_done), 1);
        @(negedge clk); irq_ack = 2'b01; @(negedge clk); idle();
        chk("R4", "alloc_done acked", int'(alloc_done), 0);

        host(3'd1, 256);
        chk("R2", "256 bytes pkt", int'(alloc_res), 3);
        chk("R2", "256 bytes one page", int'(free_pages), 14);
        host(3'd1, 257);
        chk("R2", "257 bytes pkt", int'(alloc_res), 4);
        chk("R2", "257 bytes two pages", int'(free_pages), 12);
        host(3'd1, 0);
        chk("R2", "zero length pkt", int'(alloc_res), 6);
        chk("R2", "zero length one page", int'(free_pages), 11);
        host(3'd1, 2049);
        chk("R4", "oversize fail result", int'(alloc_res), 1 << PW);
        chk("R4", "oversize keeps free", int'(free_pages), 11);

        set_pnr(3);
        host(3'd2, 0);
        chk("R5", "release one page", int'(free_pages), 12);
        host(3'd1, 512);
        chk("R3", "hole too small skipped", int'(alloc_res), 7);
        host(3'd1, 100);
        chk("R3", "hole reused", int'(alloc_res), 3);
        chk("R3", "free after refill", int'(free_pages), 9);
        set_pnr(20);
        host(3'd2, 0);
        chk("R5", "release unknown number", int'(free_pages), 9);
        set_pnr(1);
        host(3'd2, 0);
        chk("R5", "release non-start page", int'(free_pages), 9);

        // R6 enqueue / MAC pop
        set_pnr(0); host(3'd3, 0);
        set_pnr(7); host(3'd3, 0);
        chk("R6", "tx head first", int'(tx_head), 0);
        @(negedge clk); tx_pop = 1; @(negedge clk); idle();
        chk("R6", "tx head after pop", int'(tx_head), 7);

        // R8 completion queue
        @(negedge clk); done_push = 1; done_pkt = 5; @(negedge clk); done_pkt = 9;
        @(negedge clk); idle();
        host(3'd6, 0);
        chk("R8", "done head after pop", int'(done_head), 9);

        // R7 flush with simultaneous push, receive queue untouched
        @(negedge clk); rx_push = 1; rx_push_pkt = 2; @(negedge clk); idle();
        @(negedge clk); cmd_valid = 1; cmd_op = 3'd4; done_push = 1; done_pkt = 11;
        @(negedge clk); idle();
        chk("R7", "tx flushed", int'(tx_empty), 1);
        chk("R7", "done flushed over push", int'(done_empty), 1);
        chk("R7", "rx kept", int'(rx_head), 2);

        // R9/R10 reserve blocks receive
        tx_reserve = CW'(9);
        @(negedge clk); rx_alloc_req = 1; rx_len = 256; @(negedge clk); idle();
        chk("R9", "grant pulse", int'(rx_grant), 1);
        chk("R10", "grant failed on reserve", int'(rx_grant_fail), 1);
        chk("R10", "overrun set", int'(rx_ovrn), 1);
        @(negedge clk);
        chk("R9", "grant one cycle", int'(rx_grant), 0);
        chk("R10", "overrun latched", int'(rx_ovrn), 1);
        irq_ack = 2'b10; @(negedge clk); idle();
        chk("R10", "overrun acked", int'(rx_ovrn), 0);
        tx_reserve = CW'(8);
        @(negedge clk); rx_alloc_req = 1; rx_len = 256; @(negedge clk); idle();
        chk("R9", "grant ok", int'(rx_grant_fail), 0);
        chk("R9", "grant pkt", int'(rx_grant_pkt), 9);

        // R11 same-cycle host and receive
        tx_reserve = 0;
        @(negedge clk); cmd_valid = 1; cmd_op = 3'd1; cmd_len = 256;
        rx_alloc_req = 1; rx_len = 256; @(negedge clk); idle();
        chk("R11", "host first", int'(alloc_res), 10);
        chk("R11", "rx after host", int'(rx_grant_pkt), 11);

        // R12 mapping
        set_pnr(7);
        @(negedge clk); map_sel = 0; map_off = 11'h1FF; #1;
        chk("R12", "tx map", int'(map_addr), 8 * 256 + 255);
        map_sel = 1; map_off = 11'h305; #1;
        chk("R12", "rx map", int'(map_addr), 5 * 256 + 5);

        // R13 queue full
        for (int i = 0; i < DEP + 1; i++) host(3'd3, 0);
        for (int i = 0; i < DEP - 1; i++) begin @(negedge clk); tx_pop = 1; end
        @(negedge clk); idle();
        chk("R13", "one entry left", int'(tx_empty), 0);
        @(negedge clk); tx_pop = 1; @(negedge clk); idle();
        chk("R13", "full push dropped", int'(tx_empty), 1);

        // randomized phase, checked against the model every clock
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            idle();
            cmd_valid    = ($urandom_range(0, 1) == 1);
            cmd_op       = 3'($urandom_range(1, 6));
            cmd_len      = LW'($urandom_range(0, 2200));
            pnr_wr       = ($urandom_range(0, 3) == 0);
            pnr_wdata    = PW'($urandom_range(0, 20));
            irq_ack      = 2'($urandom_range(0, 3) & (($urandom_range(0, 3) == 0) ? 3 : 0));
            tx_pop       = ($urandom_range(0, 2) == 0);
            done_push    = ($urandom_range(0, 2) == 0);
            done_pkt     = PW'($urandom_range(0, 31));
            rx_alloc_req = ($urandom_range(0, 3) == 0);
            rx_len       = LW'($urandom_range(0, 2200));
            rx_push      = ($urandom_range(0, 2) == 0);
            rx_push_pkt  = PW'($urandom_range(0, 31));
            tx_reserve   = CW'($urandom_range(0, 6));
            map_sel      = ($urandom_range(0, 1) == 1);
            map_off      = 11'($urandom_range(0, 2047));
        end
        @(negedge clk); idle();
        @(negedge clk);
        finish_run();
    end
endmodule